// File: doc/BRIEF.md
# Queue status and interrupt register bank

This block is the status and interrupt front end of a 64-queue hardware queue manager. Each cycle the queue engine presents per-queue condition flags: empty, nearly empty, nearly full and full for every queue, and underflow and overflow for the lower 32 queues. The block packs these flags into read-only status words. It turns one selected condition per queue into a pending interrupt bit and masks the pending bits with per-queue enables. From the result it drives one interrupt line for queues 0–31 and one for queues 32–63. Software reaches every register through a simple single-cycle bus whose read data is registered.

The two groups are not alike. Each lower queue has a 4-bit status field and a programmable 3-bit condition code. The upper group has only a nearly-empty vector and a full vector, and its interrupt condition is always "nearly empty". One global bit chooses between two modes. In level mode a pending bit tracks the condition. In sticky mode a pending bit is set on a rising edge of the condition and is held until software acknowledges it.

Top module: `qstat_irq_bank`

## Requirements
- R1: A read (bus_sel=1, bus_wr=0) returns its data on bus_rdata one cycle later, and bus_rdata holds that value until the next read. Queue q<32 has its status at byte address 0x400+4*(q/8), bits [4*(q%8)+3:4*(q%8)], coded as bit0 empty, bit1 nearly empty, bit2 nearly full, bit3 full.
- R2: The error status of queue q<32 is at 0x410+4*(q/16). Bit 2*(q%16) is underflow and bit 2*(q%16)+1 is overflow.
- R3: For queues 32–63, the nearly-empty flags are at 0x418 and the full flags are at 0x41C, with queue q at bit q-32.
- R4: The condition selects for queues 0–31 are at 0x420+4*(q/8). Each queue has a 4-bit field at bits [4*(q%8)+3:4*(q%8)], and only its low 3 bits are stored. Field bit 3 reads 0, except bit 3 of the word at 0x420, which is the sticky-mode bit and reads back as written.
- R5: Condition codes: 0 empty, 1 nearly empty, 2 nearly full, 3 full, 4 not empty, 5 not nearly empty, 6 not nearly full, 7 not full.
- R6: The interrupt condition of each queue 32–63 is always its nearly-empty flag.
- R7: In sticky mode, a pending bit is set by a 0→1 change of its condition. It stays set until a write with a 1 in its position to 0x438 (queues 0–31) or 0x43C (queues 32–63). If the condition stays high, the bit is not set again.
- R8: In level mode, each pending bit equals its condition one clock earlier, and writes to 0x438 and 0x43C have no effect.
- R9: The enables are read/write, at 0x430 (queues 0–31) and 0x434 (queues 32–63). irq_low is the OR over queues 0–31 of pending AND enable, and irq_upp is the same over queues 32–63. Both reflect the pending bits with no extra delay.
- R10: After reset, the condition selects, the sticky bit, the enables, the pending bits, bus_rdata, irq_low and irq_upp are all zero.
- R11: Writes to the status words (0x400–0x41C) change nothing. Reads of any unmapped or misaligned address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_empty | input | 32 | Empty flags, queues 0–31 |
| q_nempty | input | 64 | Nearly-empty flags, all queues |
| q_nfull | input | 32 | Nearly-full flags, queues 0–31 |
| q_full | input | 64 | Full flags, all queues |
| q_uflow | input | 32 | Underflow flags, queues 0–31 |
| q_oflow | input | 32 | Overflow flags, queues 0–31 |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_low | output | 1 | Interrupt, queues 0–31 |
| irq_upp | output | 1 | Interrupt, queues 32–63 |

## Verification
Four properties are checked on every clock:
- In level mode, the upper pending bits follow the delayed nearly-empty vector.
- In sticky mode, no lower pending bit drops unless an acknowledge was written.
- Read data does not change without a read.
- The lower enables do not change without a write.

Only the bench scenarios can show the rest:
- The bit positions inside each status word.
- The eight condition codes.
- That a held condition does not set a bit again after it is acknowledged.
- That enables mask the outputs.
- That unmapped and status-word writes are ignored.

// File: rtl/qsr_pkg.sv
package qsr_pkg;
    localparam int WORD_W    = 32;
    localparam int NQ_GRP    = 32;
    localparam int SEL_W     = 3;
    localparam int STAT_W    = 4;
    localparam int SLOT_W    = 4;
    localparam int BANK_BASE = 'h400;

    // word slots inside the 64-byte bank window
    localparam logic [SLOT_W-1:0] SL_STAT0 = 4'd0;
    localparam logic [SLOT_W-1:0] SL_ERR0  = 4'd4;
    localparam logic [SLOT_W-1:0] SL_ERR1  = 4'd5;
    localparam logic [SLOT_W-1:0] SL_NEUP  = 4'd6;
    localparam logic [SLOT_W-1:0] SL_FUP   = 4'd7;
    localparam logic [SLOT_W-1:0] SL_SEL0  = 4'd8;
    localparam logic [SLOT_W-1:0] SL_EN0   = 4'd12;
    localparam logic [SLOT_W-1:0] SL_EN1   = 4'd13;
    localparam logic [SLOT_W-1:0] SL_PND0  = 4'd14;
    localparam logic [SLOT_W-1:0] SL_PND1  = 4'd15;

    typedef struct packed {
        logic [NQ_GRP-1:0][SEL_W-1:0] sel;
        logic                         sticky;
        logic [NQ_GRP-1:0]            en_low;
        logic [NQ_GRP-1:0]            en_upp;
        logic [WORD_W-1:0]            rdata;
    } regs_t;
endpackage

// File: rtl/qsr_src_select.sv
module qsr_src_select #(
    parameter int N = 32,
    parameter int SW = 3
) (
    input  logic [N-1:0][SW-1:0] codes,
    input  logic [N-1:0]         empty,
    input  logic [N-1:0]         nempty,
    input  logic [N-1:0]         nfull,
    input  logic [N-1:0]         full,
    output logic [N-1:0]         cond
);
    // code[1:0] picks the flag, code[2] inverts it
    for (genvar i = 0; i < N; i++) begin : g_q
        logic [3:0] flags;
        assign flags   = {full[i], nfull[i], nempty[i], empty[i]};
        assign cond[i] = codes[i][SW-1] ^ flags[codes[i][1:0]];
    end
endmodule

// File: rtl/qsr_irq_bank.sv
module qsr_irq_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sticky,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pend
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] prev;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond;
        if (sticky) begin
            // a new edge wins over an acknowledge in the same cycle
            st_d.pend = (st_q.pend & ~ack) | (cond & ~st_q.prev);
        end else begin
            st_d.pend = cond;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/qstat_irq_bank.sv
module qstat_irq_bank
    import qsr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NQ_GRP-1:0] q_empty,
    input  logic [2*NQ_GRP-1:0] q_nempty,
    input  logic [NQ_GRP-1:0] q_nfull,
    input  logic [2*NQ_GRP-1:0] q_full,
    input  logic [NQ_GRP-1:0] q_uflow,
    input  logic [NQ_GRP-1:0] q_oflow,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_low,
    output logic              irq_upp
);
    localparam int STAT_PER_W = WORD_W / STAT_W;
    localparam int STAT_WORDS = NQ_GRP / STAT_PER_W;
    localparam int ERR_PER_W  = WORD_W / 2;
    localparam int ERR_WORDS  = NQ_GRP / ERR_PER_W;
    localparam int WIN_LSB    = SLOT_W + 2;

    regs_t st_d, st_q;

    logic                    hit;
    logic [SLOT_W-1:0]       slot;
    logic                    do_wr;
    logic [WORD_W-1:0]       rd_mux;
    logic [NQ_GRP-1:0]       cond_low;
    logic [NQ_GRP-1:0]       pend_low, pend_upp;
    logic [NQ_GRP-1:0]       ack_low, ack_upp;
    logic [STAT_WORDS-1:0][WORD_W-1:0] stat_w;
    logic [ERR_WORDS-1:0][WORD_W-1:0]  err_w;
    logic [STAT_WORDS-1:0][WORD_W-1:0] sel_w;

    assign hit  = (bus_addr[ADDR_W-1:WIN_LSB] == (ADDR_W-WIN_LSB)'(BANK_BASE >> WIN_LSB))
                  && (bus_addr[1:0] == 2'b00);
    assign slot = bus_addr[WIN_LSB-1:2];
    assign do_wr = bus_sel && bus_wr && hit;

    assign ack_low = (do_wr && slot == SL_PND0) ? bus_wdata : '0;
    assign ack_upp = (do_wr && slot == SL_PND1) ? bus_wdata : '0;

    // packed status, error and select readback words
    always_comb begin
        stat_w = '0;
        err_w  = '0;
        sel_w  = '0;
        for (int q = 0; q < NQ_GRP; q++) begin
            stat_w[q/STAT_PER_W][STAT_W*(q%STAT_PER_W) +: STAT_W] =
                {q_full[q], q_nfull[q], q_nempty[q], q_empty[q]};
            err_w[q/ERR_PER_W][2*(q%ERR_PER_W) +: 2] = {q_oflow[q], q_uflow[q]};
            sel_w[q/STAT_PER_W][STAT_W*(q%STAT_PER_W) +: STAT_W] = {1'b0, st_q.sel[q]};
        end
        sel_w[0][SEL_W] = st_q.sticky;
    end

    always_comb begin
        rd_mux = '0;
        if (hit) begin
            if (slot < SL_ERR0)        rd_mux = stat_w[slot[1:0]];
            else if (slot == SL_ERR0)  rd_mux = err_w[0];
            else if (slot == SL_ERR1)  rd_mux = err_w[1];
            else if (slot == SL_NEUP)  rd_mux = q_nempty[2*NQ_GRP-1:NQ_GRP];
            else if (slot == SL_FUP)   rd_mux = q_full[2*NQ_GRP-1:NQ_GRP];
            else if (slot < SL_EN0)    rd_mux = sel_w[slot[1:0]];
            else if (slot == SL_EN0)   rd_mux = st_q.en_low;
            else if (slot == SL_EN1)   rd_mux = st_q.en_upp;
            else if (slot == SL_PND0)  rd_mux = pend_low;
            else                       rd_mux = pend_upp;
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_sel && !bus_wr) st_d.rdata = rd_mux;
        if (do_wr) begin
            if (slot >= SL_SEL0 && slot < SL_EN0) begin
                for (int j = 0; j < STAT_PER_W; j++) begin
                    st_d.sel[STAT_PER_W*int'(slot[1:0]) + j] = bus_wdata[STAT_W*j +: SEL_W];
                end
                if (slot == SL_SEL0) st_d.sticky = bus_wdata[SEL_W];
            end
            if (slot == SL_EN0) st_d.en_low = bus_wdata;
            if (slot == SL_EN1) st_d.en_upp = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    qsr_src_select #(.N(NQ_GRP), .SW(SEL_W)) u_sel (
        .codes (st_q.sel),
        .empty (q_empty),
        .nempty(q_nempty[NQ_GRP-1:0]),
        .nfull (q_nfull),
        .full  (q_full[NQ_GRP-1:0]),
        .cond  (cond_low)
    );

    qsr_irq_bank #(.N(NQ_GRP)) u_irq_low (
        .clk   (clk),
        .rst_n (rst_n),
        .sticky(st_q.sticky),
        .cond  (cond_low),
        .ack   (ack_low),
        .pend  (pend_low)
    );

    qsr_irq_bank #(.N(NQ_GRP)) u_irq_upp (
        .clk   (clk),
        .rst_n (rst_n),
        .sticky(st_q.sticky),
        .cond  (q_nempty[2*NQ_GRP-1:NQ_GRP]),
        .ack   (ack_upp),
        .pend  (pend_upp)
    );

    assign bus_rdata = st_q.rdata;
    assign irq_low   = |(pend_low & st_q.en_low);
    assign irq_upp   = |(pend_upp & st_q.en_upp);
endmodule

// File: rtl/qsr_checker.sv
module qsr_checker #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sticky,
    input logic [N-1:0] pend_low,
    input logic [N-1:0] pend_upp,
    input logic [N-1:0] ack_low,
    input logic [N-1:0] cond_upp,
    input logic [N-1:0] en_low,
    input logic         rd_req,
    input logic         wr_req,
    input logic [31:0]  rdata
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_LEVEL_TRACKS_NE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(sticky)) |-> (pend_upp == $past(cond_upp))); // R8

    AST_STICKY_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(sticky) && ($past(ack_low) == '0)) |-> (($past(pend_low) & ~pend_low) == '0)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(rd_req)) |-> $stable(rdata)); // R1

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(wr_req)) |-> $stable(en_low)); // R9
endmodule

bind qstat_irq_bank qsr_checker #(.N(qsr_pkg::NQ_GRP)) u_qsr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sticky  (st_q.sticky),
    .pend_low(pend_low),
    .pend_upp(pend_upp),
    .ack_low (ack_low),
    .cond_upp(q_nempty[63:32]),
    .en_low  (st_q.en_low),
    .rd_req  (bus_sel && !bus_wr),
    .wr_req  (bus_sel && bus_wr),
    .rdata   (bus_rdata)
);

// File: tb/qstat_irq_bank_bench.sv
module qstat_irq_bank_bench;
    localparam int ADDR_W = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] q_empty = '0, q_nfull = '0, q_uflow = '0, q_oflow = '0;
    logic [63:0] q_nempty = '0, q_full = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_low, irq_upp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qstat_irq_bank #(.ADDR_W(ADDR_W)) u_qstat_irq_bank (
        .clk, .rst_n, .q_empty, .q_nempty, .q_nfull, .q_full, .q_uflow, .q_oflow,
        .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq_low, .irq_upp
    );

    // {queue, code, flags {full,nfull,nempty,empty}, expected condition}
    localparam logic [12:0] TBL [8] = '{
        {5'd0,  3'd0, 4'b0001, 1'b1},
        {5'd5,  3'd1, 4'b0010, 1'b1},
        {5'd9,  3'd2, 4'b0000, 1'b0},
        {5'd13, 3'd3, 4'b1000, 1'b1},
        {5'd17, 3'd4, 4'b0001, 1'b0},
        {5'd22, 3'd5, 4'b0000, 1'b1},
        {5'd26, 3'd6, 4'b0100, 1'b0},
        {5'd31, 3'd7, 4'b0000, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    logic [31:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 rdata", bus_rdata, 32'h0);
        chk("R10 irq", {30'h0, irq_upp, irq_low}, 32'h0);
        rd(14'h430, v); chk("R10 enable low", v, 32'h0);
        rd(14'h420, v); chk("R10 select word0", v, 32'h0);
        rd(14'h438, v); chk("R10 pending low", v, 32'h0);

        // R1 status packing
        q_empty = 32'h1; q_nempty = 64'h200; q_nfull = 32'h4_0000; q_full = 64'h8000_0000;
        rd(14'h400, v); chk("R1 status word0", v, 32'h0000_0001);
        rd(14'h404, v); chk("R1 status word1", v, 32'h0000_0020);
        rd(14'h408, v); chk("R1 status word2", v, 32'h0000_0400);
        rd(14'h40C, v); chk("R1 status word3", v, 32'h8000_0000);
        // R11 status words are read-only
        wr(14'h400, 32'hFFFF_FFFF);
        rd(14'h400, v); chk("R11 status write ignored", v, 32'h0000_0001);
        q_empty = '0; q_nempty = '0; q_nfull = '0; q_full = '0;

        // R2 underflow/overflow packing
        q_uflow = 32'h8; q_oflow = 32'h10_0000;
        rd(14'h410, v); chk("R2 error word0", v, 32'h0000_0040);
        rd(14'h414, v); chk("R2 error word1", v, 32'h0000_0200);
        q_uflow = '0; q_oflow = '0;

        // R3 upper vectors
        q_nempty = 64'h100 << 32; q_full = 64'h8000_0000 << 32;
        rd(14'h418, v); chk("R3 upper nearly-empty", v, 32'h0000_0100);
        rd(14'h41C, v); chk("R3 upper full", v, 32'h8000_0000);
        q_nempty = '0; q_full = '0;

        // R4 select storage, reserved bits
        wr(14'h42C, 32'hFFFF_FFFF);
        rd(14'h42C, v); chk("R4 select reserved bits", v, 32'h7777_7777);
        wr(14'h42C, 32'h0);
        // R11 unmapped / misaligned
        rd(14'h500, v); chk("R11 unmapped read", v, 32'h0);
        wr(14'h430, 32'hA5);
        rd(14'h431, v); chk("R11 misaligned read", v, 32'h0);
        wr(14'h430, 32'h0);

        // R5 condition codes, level mode, table walk
        for (int i = 0; i < 8; i++) begin
            automatic logic [4:0] qi = TBL[i][12:8];
            automatic logic [2:0] cd = TBL[i][7:5];
            automatic logic [3:0] fl = TBL[i][4:1];
            automatic logic       ex = TBL[i][0];
            wr(14'h420 + 14'(4 * (qi / 8)), 32'(cd) << (4 * (qi % 8)));
            wr(14'h430, 32'h1 << qi);
            q_empty = 32'(fl[0]) << qi; q_nempty = 64'(fl[1]) << qi;
            q_nfull = 32'(fl[2]) << qi; q_full   = 64'(fl[3]) << qi;
            tick();
            chk("R5 irq_low for code", {31'h0, irq_low}, {31'h0, ex});
            rd(14'h438, v); chk("R9 pending word", v, 32'(ex) << qi);
            wr(14'h420 + 14'(4 * (qi / 8)), 32'h0);
            q_empty = '0; q_nempty = '0; q_nfull = '0; q_full = '0;
            tick();
        end
        wr(14'h430, 32'h0);

        // R6 / R8 upper group, level mode
        wr(14'h434, 32'h1);
        q_full = 64'h1 << 32;
        tick();
        chk("R6 full does not raise upper", {31'h0, irq_upp}, 32'h0);
        q_nempty = 64'h1 << 32;
        tick();
        chk("R6 nearly-empty raises upper", {31'h0, irq_upp}, 32'h1);
        wr(14'h43C, 32'h1);
        rd(14'h43C, v); chk("R8 ack ignored in level mode", v, 32'h1);
        q_nempty = '0; q_full = '0;
        tick();
        chk("R8 follows level down", {31'h0, irq_upp}, 32'h0);
        wr(14'h434, 32'h0);

        // R7 sticky mode on queue 0 (code empty)
        wr(14'h420, 32'h8);
        wr(14'h430, 32'h1);
        q_empty[0] = 1'b1;
        tick();
        q_empty[0] = 1'b0;
        tick();
        chk("R7 held after condition falls", {31'h0, irq_low}, 32'h1);
        wr(14'h438, 32'h0);
        rd(14'h438, v); chk("R7 zero write keeps bit", v, 32'h1);
        // R9 masking
        wr(14'h430, 32'h0);
        chk("R9 disabled masks irq", {31'h0, irq_low}, 32'h0);
        rd(14'h438, v); chk("R9 pending kept while masked", v, 32'h1);
        wr(14'h430, 32'h1);
        q_empty[0] = 1'b1;
        tick();
        wr(14'h438, 32'h1);
        rd(14'h438, v); chk("R7 ack clears, no re-set while high", v, 32'h0);
        chk("R7 irq low after ack", {31'h0, irq_low}, 32'h0);
        q_empty[0] = 1'b0;
        tick();
        q_empty[0] = 1'b1;
        tick();
        chk("R7 new edge sets again", {31'h0, irq_low}, 32'h1);
        rd(14'h420, v); chk("R4 sticky bit readback", v, 32'h8);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule